// File: doc/BRIEF.md
# GPIO Interrupt Detector

This block watches a bank of general-purpose input pins, already synchronized to the local clock, and turns their activity into interrupt requests. Each pin has its own configuration. It can be level-sensitive, either active-high or active-low. It can instead be edge-sensitive, on the rising edge, the falling edge, or both edges. A pin's raw status is transparent in level mode. In edge mode the raw status is held in a latch that software clears by writing ones to a clear register. An enable register masks the raw status. The OR of the masked bits drives one registered interrupt line toward the parent interrupt controller.

Software reaches the block through a small register port. Writes take effect on the clock edge. Reads are combinational from a 3-bit register index. The interrupt service routine reads the masked status, handles each set bit, and writes those bits to the clear register for pins in edge mode. Pins in level mode need no clear: their status falls as soon as the input leaves the active level.

Top module: `gpio_irq_detect`

## Requirements
- R1: After a synchronous active-low reset, every configuration and enable register reads zero, raw and masked status read zero and `irq_out` is 0. Pins that are already high while reset is held do not produce an edge after release.
- R2: With a pin's level-select bit at 1, its raw status is 1 exactly while the input equals its polarity bit (1 = active-high, 0 = active-low). The status falls by itself, and edges seen in level mode are never latched.
- R3: With level-select 0 and dual-edge 0, a pin latches a rising edge when its polarity bit is 1 and a falling edge when it is 0. The latched status is visible on the cycle after the edge and holds until it is cleared.
- R4: With level-select 0 and dual-edge 1, a pin latches on both rising and falling edges, and its polarity bit has no effect.
- R5: Masked status equals raw status AND enable. Clearing an enable bit leaves that pin's raw status unchanged.
- R6: Writing the clear register clears the latched edge status of each pin whose data bit is 1. Pins whose data bit is 0 keep their status.
- R7: When an edge event and a clear for the same pin fall on the same clock edge, the pin's status stays set.
- R8: `irq_out` is a register holding the OR of all masked status bits. It follows a change of masked status one clock edge later.
- R9: Changing the polarity or level-select configuration does not clear latched edge status. A pin moved to level mode and back to edge mode shows its latch again.
- R10: Register index map: 0 level-select, 1 dual-edge, 2 polarity, 3 enable (all read/write), 4 raw status, 5 masked status (read-only), 6 clear (write-only, reads 0), 7 unused (reads 0). Writes to indices 4, 5 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | NPINS | Synchronized GPIO inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Combinational read data for `reg_addr` |
| irq_out | output | 1 | Registered combined interrupt request |

## Verification
The level path is swept over all 256 input patterns under two mixed polarity words. This separates active-high pins from active-low ones, and it confirms afterwards that nothing was latched while in level mode. The edge path is swept over 256 before/after pin transitions. The single-edge sweep splits the polarity word so that rising and falling pins are told apart. The dual-edge sweep runs under both polarity extremes to show that polarity is ignored there. Directed sequences cover a clear that meets a new event on the same edge, partial and zero clears, the one-edge delay of the interrupt through the enable mask, configuration changes on latched pins, and writes to read-only indices.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
// Package: register index map shared by the interrupt detector and its bench.
// Assumes a 3-bit register index; the index values are part of the software view.
package gpio_irq_pkg;
    localparam int ADDR_W = 3;
    localparam int NUM_CFG = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_LVL_SEL  = 3'd0,
        RA_DUAL     = 3'd1,
        RA_POL      = 3'd2,
        RA_UNMASK   = 3'd3,
        RA_RAW      = 3'd4,
        RA_MASKED   = 3'd5,
        RA_CLEAR    = 3'd6,
        RA_SPARE    = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
`timescale 1ns/1ps
// Module: configuration register file plus clear-pulse decode.
// Holds level-select, dual-edge, polarity and enable words; write-1-to-clear
// produces a single-cycle clear vector. Assumes single-cycle write strobes.
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NPINS-1:0]     wdata,
    output logic [NPINS-1:0]     mode_lvl,
    output logic [NPINS-1:0]     dual_edge,
    output logic [NPINS-1:0]     act_hi,
    output logic [NPINS-1:0]     unmask,
    output logic [NPINS-1:0]     clr_pulse
);
    logic [NPINS-1:0] cfg_q [NUM_CFG];

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        // Purpose: writable configuration word g, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[g] <= '0;
            end else if (wr && (addr == ADDR_W'(g))) begin
                cfg_q[g] <= wdata;
            end
        end
    end

    assign mode_lvl  = cfg_q[RA_LVL_SEL];
    assign dual_edge = cfg_q[RA_DUAL];
    assign act_hi    = cfg_q[RA_POL];
    assign unmask    = cfg_q[RA_UNMASK];

    // Purpose: one-cycle clear vector from a write to the clear index.
    always_comb begin
        clr_pulse = '0;
        if (wr && (addr == RA_CLEAR)) begin
            clr_pulse = wdata;
        end
    end
endmodule

// File: rtl/gpio_irq_cell.sv
`timescale 1ns/1ps
// Module: per-pin detector. Tracks the previous input to find edges, latches
// edge events until cleared and forms the raw status (transparent level or
// latched edge). Assumes pin is already synchronous to clk.
module gpio_irq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic mode_lvl,
    input  logic dual_edge,
    input  logic act_hi,
    input  logic clr,
    output logic ev,
    output logic raw
);
    logic prev_q;
    logic latch_q;
    logic rise;
    logic fall;

    // Purpose: previous-sample register; reset loads the live pin so no false edge appears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= pin;
        end else begin
            prev_q <= pin;
        end
    end

    // Purpose: edge classification and event selection by mode.
    always_comb begin
        rise = pin & ~prev_q;
        fall = ~pin & prev_q;
        if (mode_lvl) begin
            ev = 1'b0;
        end else if (dual_edge) begin
            ev = rise | fall;
        end else begin
            ev = act_hi ? rise : fall;
        end
    end

    // Purpose: edge status latch; a new event outranks a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
        end else if (ev) begin
            latch_q <= 1'b1;
        end else if (clr) begin
            latch_q <= 1'b0;
        end
    end

    // Purpose: raw status view, level compare or latched edge.
    always_comb begin
        if (mode_lvl) begin
            raw = ~(pin ^ act_hi);
        end else begin
            raw = latch_q;
        end
    end
endmodule

// File: rtl/gpio_irq_rdmux.sv
`timescale 1ns/1ps
// Module: combinational read multiplexer over the register index.
// Clear and unused indices read zero.
module gpio_irq_rdmux
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  mode_lvl,
    input  logic [NPINS-1:0]  dual_edge,
    input  logic [NPINS-1:0]  act_hi,
    input  logic [NPINS-1:0]  unmask,
    input  logic [NPINS-1:0]  raw_st,
    input  logic [NPINS-1:0]  masked_st,
    output logic [NPINS-1:0]  rdata
);
    // Purpose: select the register addressed by the index.
    always_comb begin
        case (addr)
            RA_LVL_SEL: rdata = mode_lvl;
            RA_DUAL:    rdata = dual_edge;
            RA_POL:     rdata = act_hi;
            RA_UNMASK:  rdata = unmask;
            RA_RAW:     rdata = raw_st;
            RA_MASKED:  rdata = masked_st;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
// Module: top of the GPIO interrupt detector. One detector cell per pin,
// a shared configuration file, masking and a registered combined request.
// Assumes inputs are synchronized upstream; data/direction paths live elsewhere.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    output logic              irq_out
);
    logic [NPINS-1:0] mode_lvl;
    logic [NPINS-1:0] dual_edge;
    logic [NPINS-1:0] act_hi;
    logic [NPINS-1:0] unmask;
    logic [NPINS-1:0] clr_vec;
    logic [NPINS-1:0] edge_ev;
    logic [NPINS-1:0] raw_st;
    logic [NPINS-1:0] masked_st;
    logic             irq_q;

    gpio_irq_cfg #(.NPINS(NPINS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .mode_lvl  (mode_lvl),
        .dual_edge (dual_edge),
        .act_hi    (act_hi),
        .unmask    (unmask),
        .clr_pulse (clr_vec)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_irq_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin       (pin_in[i]),
            .mode_lvl  (mode_lvl[i]),
            .dual_edge (dual_edge[i]),
            .act_hi    (act_hi[i]),
            .clr       (clr_vec[i]),
            .ev        (edge_ev[i]),
            .raw       (raw_st[i])
        );
    end

    assign masked_st = raw_st & unmask;

    // Purpose: registered OR of all masked status bits toward the parent controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |masked_st;
        end
    end

    assign irq_out = irq_q;

    gpio_irq_rdmux #(.NPINS(NPINS)) u_rdmux (
        .addr      (reg_addr),
        .mode_lvl  (mode_lvl),
        .dual_edge (dual_edge),
        .act_hi    (act_hi),
        .unmask    (unmask),
        .raw_st    (raw_st),
        .masked_st (masked_st),
        .rdata     (reg_rdata)
    );
endmodule

// File: rtl/gpio_irq_detect_chk.sv
`timescale 1ns/1ps
// Module: assertion checker bound into gpio_irq_detect. Observes the status,
// event and clear vectors and the combined request over time.
module gpio_irq_detect_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] mode_lvl,
    input logic [NPINS-1:0] edge_ev,
    input logic [NPINS-1:0] clr_vec,
    input logic [NPINS-1:0] raw_st,
    input logic [NPINS-1:0] masked_st,
    input logic             irq_out
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq_out == 1'b0 && raw_st == '0));

    assert_latch_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(raw_st & ~mode_lvl & ~clr_vec) & ~mode_lvl & ~raw_st) == '0));

    assert_mask_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_st & ~raw_st) == '0);

    assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(clr_vec & ~edge_ev & ~mode_lvl) & ~mode_lvl & raw_st) == '0));

    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(edge_ev) & ~mode_lvl & ~raw_st) == '0));

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_out == $past(|masked_st)));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_lvl  (mode_lvl),
    .edge_ev   (edge_ev),
    .clr_vec   (clr_vec),
    .raw_st    (raw_st),
    .masked_st (masked_st),
    .irq_out   (irq_out)
);

// File: tb/tb_gpio_irq_detect.sv
`timescale 1ns/1ps
module tb_gpio_irq_detect;
    localparam int NP = 8;
    localparam logic [2:0] A_LVL = 3'd0, A_DUAL = 3'd1, A_POL = 3'd2, A_EN = 3'd3,
                           A_RAW = 3'd4, A_MSK = 3'd5, A_CLR = 3'd6, A_SPARE = 3'd7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [NP-1:0] reg_wdata = '0;
    logic [NP-1:0] reg_rdata;
    logic          irq_out;
    int            checks = 0;
    int            fails = 0;

    gpio_irq_detect #(.NPINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [NP-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [NP-1:0] v;
        logic [NP-1:0] a;
        logic [NP-1:0] b;
        logic [NP-1:0] pol;

        // R1: reset with some pins high; no false edge after release
        pin_in = 8'hA5;
        repeat (3) step();
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            chk($sformatf("R1 reset read idx %0d", i), v, '0);
        end
        step(); step();
        rd(A_RAW, v);
        chk("R1 no false edge after reset", v, '0);
        chk("R1 irq low after reset", {7'd0, irq_out}, '0);

        // R2: level mode sweep, two polarity words
        wr(A_LVL, 8'hFF);
        for (int p = 0; p < 2; p++) begin
            pol = (p == 0) ? 8'h5A : 8'hC3;
            wr(A_POL, pol);
            for (int k = 0; k < 256; k++) begin
                pin_in = 8'(k);
                rd(A_RAW, v);
                chk("R2 level raw", v, ~(8'(k) ^ pol));
                step();
            end
        end
        pin_in = 8'h00;
        step();
        wr(A_LVL, 8'h00);
        rd(A_RAW, v);
        chk("R2 nothing latched in level mode", v, '0);

        // R3: single-edge sweep, upper pins rising, lower pins falling
        wr(A_POL, 8'hF0);
        wr(A_DUAL, 8'h00);
        for (int k = 0; k < 256; k++) begin
            b = 8'(k);
            a = {b[3:0], b[7:4]} ^ 8'h96;
            pin_in = a; step();
            wr(A_CLR, 8'hFF);
            pin_in = b; step();
            rd(A_RAW, v);
            chk("R3 single edge", v, (~a & b & 8'hF0) | (a & ~b & 8'h0F));
            step();
            rd(A_RAW, v);
            chk("R3 latch holds", v, (~a & b & 8'hF0) | (a & ~b & 8'h0F));
        end

        // R4: dual-edge sweep under both polarity extremes
        wr(A_DUAL, 8'hFF);
        for (int p = 0; p < 2; p++) begin
            wr(A_POL, (p == 0) ? 8'h00 : 8'hFF);
            for (int k = 0; k < 256; k++) begin
                b = 8'(k);
                a = {b[2:0], b[7:3]} ^ 8'h3C;
                pin_in = a; step();
                wr(A_CLR, 8'hFF);
                pin_in = b; step();
                rd(A_RAW, v);
                chk("R4 dual edge", v, a ^ b);
            end
        end

        // R6: zero clear and partial clear
        pin_in = 8'h00; step();
        wr(A_CLR, 8'hFF);
        pin_in = 8'h99; step();
        wr(A_CLR, 8'h00);
        rd(A_RAW, v);
        chk("R6 zero clear keeps status", v, 8'h99);
        wr(A_CLR, 8'h0F);
        rd(A_RAW, v);
        chk("R6 partial clear", v, 8'h90);

        // R7: event and clear on the same edge
        pin_in = 8'h00; step();
        wr(A_CLR, 8'hFF);
        pin_in = 8'h30; step();
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_CLR; reg_wdata = 8'hFF; pin_in = 8'h33;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(A_RAW, v);
        chk("R7 event wins over clear", v, 8'h03);

        // R5 and R8: masking and registered interrupt
        wr(A_CLR, 8'hFF);
        pin_in = 8'hB2; step();
        rd(A_RAW, v);
        chk("R5 latched setup", v, 8'h81);
        wr(A_EN, 8'h01);
        rd(A_MSK, v);
        chk("R5 masked equals raw and enable", v, 8'h01);
        chk("R8 irq not yet updated", {7'd0, irq_out}, 8'h00);
        step();
        chk("R8 irq one edge later", {7'd0, irq_out}, 8'h01);
        wr(A_EN, 8'h7E);
        rd(A_MSK, v);
        chk("R5 disjoint enable", v, 8'h00);
        rd(A_RAW, v);
        chk("R5 raw kept while masked", v, 8'h81);
        chk("R8 irq holds previous", {7'd0, irq_out}, 8'h01);
        step();
        chk("R8 irq falls one edge later", {7'd0, irq_out}, 8'h00);
        wr(A_EN, 8'hFF);
        step();
        chk("R8 irq full enable", {7'd0, irq_out}, 8'h01);

        // R9: configuration changes keep latched edges
        wr(A_POL, 8'h5A);
        rd(A_RAW, v);
        chk("R9 polarity change keeps latch", v, 8'h81);
        wr(A_LVL, 8'hFF);
        rd(A_RAW, v);
        chk("R9 level view", v, ~(8'hB2 ^ 8'h5A));
        wr(A_LVL, 8'h00);
        rd(A_RAW, v);
        chk("R9 latch back after level mode", v, 8'h81);

        // R10: read-only and unused indices
        wr(A_RAW, 8'h00);
        wr(A_MSK, 8'h00);
        wr(A_SPARE, 8'hFF);
        rd(A_RAW, v);
        chk("R10 raw ignores writes", v, 8'h81);
        rd(A_MSK, v);
        chk("R10 masked ignores writes", v, 8'h81);
        rd(A_SPARE, v);
        chk("R10 spare reads zero", v, 8'h00);
        rd(A_CLR, v);
        chk("R10 clear reads zero", v, 8'h00);
        rd(A_DUAL, v);
        chk("R10 dual-edge unchanged", v, 8'hFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule